// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Interface

This block is the bus-facing half of a serial byte memory that answers on a two-wire, open-drain bus. It watches the clock and data lines after they have been synchronised to a fast system clock. It finds bus start and stop conditions, and it decodes the 8-bit device select byte against a fixed 4-bit type code and three board strap pins. It then takes two array-address bytes, most significant first, and either accepts write data or streams read data back most significant bit first. It pulls the data line low to acknowledge, and it pulls it low for every zero bit it returns.

On the memory side, the block keeps the byte address pointer. It emits a one-cycle strobe for every accepted write byte, and a one-cycle request for every byte the master is about to read. Both carry the access address. It also pulses a flag on every bus stop, so that the memory controller can start its internal program cycle. The controller returns two flags. One says that a program cycle is running, and while it is set the slave stays silent on its own address, which lets the master poll for completion. The other refuses write data because the array is protected.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset, and until a start condition (data falling while clock is high) is seen, `sda_pull_o` stays 0 whatever is clocked on the bus. A stop condition (data rising while clock is high) returns the block to this idle state from any state.
- R2: A select byte is acknowledged, by `sda_pull_o` = 1 during the 9th clock, only when bits 7..4 equal 1010 and bits 3..1 equal `strap_i[2:0]`. Bit 0 = 1 selects read and bit 0 = 0 selects write. On any other value the block does not acknowledge, and it ignores all further bytes until the next start or stop.
- R3: After a write select, two address bytes follow, high byte first, and both are acknowledged. The pointer becomes {high byte bits 4..0, low byte}, a 13-bit address. High byte bits 7..5 are ignored.
- R4: Each further byte of a write is acknowledged and produces one `wr_stb_o` pulse, with the byte on `wr_data_o` and its address on `acc_addr_o`.
- R5: After each stored byte, the write pointer advances within its 32-byte page: bits 4..0 count up and wrap to 0, and bits 12..5 stay unchanged.
- R6: While `busy_i` = 1 at the end of a select byte, the select byte is not acknowledged, even when it matches. Once `busy_i` returns to 0, the same byte is acknowledged.
- R7: While `wp_nack_i` = 1, the address bytes are still acknowledged. Write data bytes are neither acknowledged nor strobed, and the pointer does not advance.
- R8: A read select issues `rd_req_o` with the pointer on `acc_addr_o`. The byte returned on `rd_data_i` is shifted out most significant bit first. `sda_pull_o` only starts a drive while the clock line is low, and it is stable during every clock-high phase.
- R9: During a read, a master acknowledge (data low in the 9th clock) requests the next byte. The read pointer runs over page boundaries and wraps from 8191 to 0. A master non-acknowledge releases the line and ends the transfer.
- R10: A read select without preceding address bytes returns the byte at the last accessed address plus one. A write select carrying the address bytes, followed by a repeated start and a read select, returns the byte at the loaded address.
- R11: Every stop condition produces exactly one `stop_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level (wired-AND of all drivers) |
| strap_i | input | 3 | Board select straps compared with select byte bits 3..1 |
| busy_i | input | 1 | Internal program cycle running; select byte is not acknowledged |
| wp_nack_i | input | 1 | Array protected; write data is refused |
| rd_data_i | input | 8 | Read byte, sampled RD_LAT clocks after the edge that raises `rd_req_o` |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| wr_stb_o | output | 1 | One-cycle pulse per accepted write byte |
| wr_data_o | output | 8 | Write byte that goes with `wr_stb_o` |
| rd_req_o | output | 1 | One-cycle request for the byte at `acc_addr_o` |
| acc_addr_o | output | ADDR_W | Address of the current write strobe or read request |
| stop_o | output | 1 | One-cycle pulse on each stop condition |

## Verification
The bench sweeps all 128 select values and all eight strap settings. A comparator that checked too few bits, or the wrong ones, would then acknowledge a foreign device. It writes across the end of a 32-byte page and reads across the top of the array. A pointer with the wrong wrap rule would then store the third byte on the next page, or hand back the wrong byte after address 8191. It also checks that a refused or ignored transfer leaves both the strobe count and the pointer unchanged, that the line is released during the master's non-acknowledge, and that read bits hold steady through each clock-high phase. A design that drove data at the wrong edge would corrupt those bits, or fake a stop condition on the bus.

// File: rtl/tw_pkg.sv
package tw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_RDAT,
      ST_IGN
   } tw_state_e;

   localparam logic [3:0] TW_MEM_TYPE = 4'b1010;

endpackage

// File: rtl/tw_bus_cond.sv
module tw_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;
   assign start_det = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
   parameter int ADDR_W    = 13,
   parameter int PAGE_BITS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc_wr,
   input  logic              inc_rd,
   output logic [ADDR_W-1:0] ptr
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] wr_next;

   generate
      if (PAGE_BITS > 0) begin : g_page
         localparam logic [PAGE_BITS-1:0] PSTEP = PAGE_BITS'(1);
         assign wr_next = {ptr_q[ADDR_W-1:PAGE_BITS], ptr_q[PAGE_BITS-1:0] + PSTEP};

         a_r5_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_wr && !load) |=> ptr_q[ADDR_W-1:PAGE_BITS] == $past(ptr_q[ADDR_W-1:PAGE_BITS]));
      end else begin : g_flat
         assign wr_next = ptr_q + STEP;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q <= '0;
      else if (load)    ptr_q <= load_val;
      else if (inc_wr)  ptr_q <= wr_next;
      else if (inc_rd)  ptr_q <= ptr_q + STEP;
   end

   assign ptr = ptr_q;

   a_r3_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ptr_q == $past(load_val));

   a_r9_read_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_rd && !load && !inc_wr) |=> ptr_q == $past(ptr_q) + STEP);

endmodule

// File: rtl/tw_tx_shift.sv
module tw_tx_shift (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] load_val,
   input  logic       shift,
   output logic       cur_bit,
   output logic       nxt_bit
);

   logic [7:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr_q <= '0;
      else if (load)  sr_q <= load_val;
      else if (shift) sr_q <= {sr_q[6:0], 1'b0};
   end

   assign cur_bit = sr_q[7];
   assign nxt_bit = sr_q[6];

endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
   import tw_pkg::*;
#(
   parameter int         ADDR_W    = 13,
   parameter int         PAGE_BITS = 5,
   parameter int         RD_LAT    = 2,
   parameter logic [3:0] DEV_TYPE  = TW_MEM_TYPE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [2:0]        strap_i,
   input  logic              busy_i,
   input  logic              wp_nack_i,
   input  logic [7:0]        rd_data_i,
   output logic              sda_pull_o,
   output logic              wr_stb_o,
   output logic [7:0]        wr_data_o,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic              stop_o
);

   localparam int         HI_W     = ADDR_W - 8;
   localparam logic [3:0] BIT_DONE = 4'd8;

   initial begin
      assert (ADDR_W >= 9 && ADDR_W <= 16) else $error("ADDR_W must lie in 9..16");
      assert (PAGE_BITS >= 0 && PAGE_BITS < ADDR_W) else $error("PAGE_BITS out of range");
      assert (RD_LAT >= 1 && RD_LAT <= 4) else $error("RD_LAT must lie in 1..4");
   end

   logic scl_rise, scl_fall, start_det, stop_det;

   tw_bus_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   tw_state_e         st, nxt;
   logic [3:0]        cnt;
   logic              in_ack;
   logic [7:0]        rx_sr;
   logic [HI_W-1:0]   hi_q;
   logic              pull_q;
   logic              mack_q;
   logic              wr_stb_q;
   logic [7:0]        wr_data_q;
   logic              rd_req_q;
   logic [ADDR_W-1:0] acc_q;
   logic              stop_q;
   logic [RD_LAT-1:0] rd_pipe;

   logic              rx_phase, ack_pt, dev_ok;
   logic              ptr_load, ptr_inc_wr, rd_first, rd_more, rd_go, tx_shift;
   logic [ADDR_W-1:0] ptr;
   logic              tx_cur, tx_nxt;

   assign rx_phase   = (st == ST_DEV) || (st == ST_AHI) || (st == ST_ALO) || (st == ST_WDAT);
   assign ack_pt     = rx_phase && scl_fall && !in_ack && (cnt == BIT_DONE);
   assign dev_ok     = (rx_sr[7:4] == DEV_TYPE) && (rx_sr[3:1] == strap_i) && !busy_i;
   assign ptr_load   = ack_pt && (st == ST_ALO);
   assign ptr_inc_wr = ack_pt && (st == ST_WDAT) && !wp_nack_i;
   assign rd_first   = ack_pt && (st == ST_DEV) && dev_ok && rx_sr[0];
   assign rd_more    = (st == ST_RDAT) && in_ack && scl_rise && !sda_i;
   assign rd_go      = rd_first || rd_more;
   assign tx_shift   = (st == ST_RDAT) && scl_fall && !in_ack && (cnt != BIT_DONE);

   tw_addr_ptr #(
      .ADDR_W    (ADDR_W),
      .PAGE_BITS (PAGE_BITS)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val ({hi_q, rx_sr}),
      .inc_wr   (ptr_inc_wr),
      .inc_rd   (rd_go),
      .ptr      (ptr)
   );

   tw_tx_shift u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (rd_pipe[RD_LAT-1]),
      .load_val (rd_data_i),
      .shift    (tx_shift),
      .cur_bit  (tx_cur),
      .nxt_bit  (tx_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_pipe <= '0;
      else        rd_pipe <= (rd_pipe << 1) | RD_LAT'(rd_go);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         nxt       <= ST_IDLE;
         cnt       <= '0;
         in_ack    <= 1'b0;
         rx_sr     <= '0;
         hi_q      <= '0;
         pull_q    <= 1'b0;
         mack_q    <= 1'b0;
         wr_stb_q  <= 1'b0;
         wr_data_q <= '0;
         rd_req_q  <= 1'b0;
         acc_q     <= '0;
         stop_q    <= 1'b0;
      end else begin
         wr_stb_q <= 1'b0;
         rd_req_q <= rd_go;
         stop_q   <= 1'b0;
         if (ptr_inc_wr || rd_go) acc_q <= ptr;

         if (stop_det) begin
            st     <= ST_IDLE;
            pull_q <= 1'b0;
            in_ack <= 1'b0;
            cnt    <= '0;
            stop_q <= 1'b1;
         end else if (start_det) begin
            st     <= ST_DEV;
            pull_q <= 1'b0;
            in_ack <= 1'b0;
            cnt    <= '0;
         end else begin
            case (st)
               ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                  if (scl_rise && !in_ack && cnt != BIT_DONE) begin
                     rx_sr <= {rx_sr[6:0], sda_i};
                     cnt   <= cnt + 4'd1;
                  end else if (ack_pt) begin
                     in_ack <= 1'b1;
                     if (st == ST_DEV) begin
                        if (dev_ok) begin
                           pull_q <= 1'b1;
                           nxt    <= rx_sr[0] ? ST_RDAT : ST_AHI;
                        end else begin
                           st <= ST_IGN;
                        end
                     end else if (st == ST_AHI) begin
                        pull_q <= 1'b1;
                        hi_q   <= rx_sr[HI_W-1:0];
                        nxt    <= ST_ALO;
                     end else if (st == ST_ALO) begin
                        pull_q <= 1'b1;
                        nxt    <= ST_WDAT;
                     end else begin
                        if (wp_nack_i) begin
                           st <= ST_IGN;
                        end else begin
                           pull_q    <= 1'b1;
                           wr_stb_q  <= 1'b1;
                           wr_data_q <= rx_sr;
                           nxt       <= ST_WDAT;
                        end
                     end
                  end else if (scl_fall && in_ack) begin
                     in_ack <= 1'b0;
                     st     <= nxt;
                     mack_q <= 1'b0;
                     if (nxt == ST_RDAT) begin
                        pull_q <= ~tx_cur;
                        cnt    <= 4'd1;
                     end else begin
                        pull_q <= 1'b0;
                        cnt    <= '0;
                     end
                  end
               end
               ST_RDAT: begin
                  if (scl_fall && !in_ack) begin
                     if (cnt != BIT_DONE) begin
                        pull_q <= ~tx_nxt;
                        cnt    <= cnt + 4'd1;
                     end else begin
                        pull_q <= 1'b0;
                        in_ack <= 1'b1;
                     end
                  end else if (scl_rise && in_ack) begin
                     mack_q <= ~sda_i;
                  end else if (scl_fall && in_ack) begin
                     in_ack <= 1'b0;
                     if (mack_q) begin
                        pull_q <= ~tx_cur;
                        cnt    <= 4'd1;
                     end else begin
                        pull_q <= 1'b0;
                        st     <= ST_IGN;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull_o = pull_q;
   assign wr_stb_o   = wr_stb_q;
   assign wr_data_o  = wr_data_q;
   assign rd_req_o   = rd_req_q;
   assign acc_addr_o = acc_q;
   assign stop_o     = stop_q;

   a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !pull_q);

   a_r2_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IGN) |-> !pull_q);

   a_r2_foreign_type: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_pt && st == ST_DEV && rx_sr[7:4] != DEV_TYPE) |=> (st == ST_IGN));

   a_r6_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_pt && st == ST_DEV && busy_i) |=> !pull_q);

   a_r7_wp_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_pt && st == ST_WDAT && wp_nack_i) |=> (!wr_stb_q && !pull_q));

   a_r8_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_q) |-> !scl_i);

   a_r8_read_change_low: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RDAT && !$stable(pull_q)) |-> !scl_i);

   a_r11_stop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (st == ST_IDLE && stop_q));

endmodule

// File: tb/sim_tw_mem_slave.sv
module sim_tw_mem_slave;

   localparam int AW = 13;
   localparam int H  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scl = 1'b1;
   logic          m_sda = 1'b1;
   logic [2:0]    strap = 3'b101;
   logic          busy = 1'b0;
   logic          wp = 1'b0;
   logic [7:0]    rd_data = '0;
   logic          pull, wr_stb, rd_req, stop_p;
   logic [7:0]    wr_data;
   logic [AW-1:0] acc_addr;
   logic          sda_bus;

   int n_chk = 0, n_fail = 0;
   int wr_cnt = 0, stop_cnt = 0;
   logic [AW-1:0] last_wa = '0;
   logic [7:0]    last_wd = '0;
   bit done = 0;

   always #2 clk = ~clk;

   assign sda_bus = m_sda & ~pull;

   tw_mem_slave u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_bus),
      .strap_i    (strap),
      .busy_i     (busy),
      .wp_nack_i  (wp),
      .rd_data_i  (rd_data),
      .sda_pull_o (pull),
      .wr_stb_o   (wr_stb),
      .wr_data_o  (wr_data),
      .rd_req_o   (rd_req),
      .acc_addr_o (acc_addr),
      .stop_o     (stop_p)
   );

   function automatic logic [7:0] pat(input logic [AW-1:0] a);
      return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
   endfunction

   always @(posedge clk) if (rd_req) rd_data <= pat(acc_addr);
   always @(posedge clk) if (wr_stb) begin
      wr_cnt  <= wr_cnt + 1;
      last_wa <= acc_addr;
      last_wd <= wr_data;
   end
   always @(posedge clk) if (stop_p) stop_cnt <= stop_cnt + 1;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bstart;
      m_sda = 1'b1; tick(H); scl = 1'b1; tick(H); m_sda = 1'b0; tick(H); scl = 1'b0; tick(H);
   endtask

   task automatic bstop;
      m_sda = 1'b0; tick(H); scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
   endtask

   task automatic sbyte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; tick(H); scl = 1'b1; tick(H); scl = 1'b0;
      end
      m_sda = 1'b1; tick(H); scl = 1'b1; tick(H/2); ack = ~sda_bus; tick(H/2); scl = 1'b0; tick(H);
   endtask

   task automatic rbyte(input logic mack, output logic [7:0] b, output logic stable, output logic rel);
      stable = 1'b1;
      m_sda  = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(H); scl = 1'b1; tick(2); b[i] = sda_bus; tick(H-2);
         if (sda_bus !== b[i]) stable = 1'b0;
         scl = 1'b0;
      end
      m_sda = ~mack; tick(H); scl = 1'b1; tick(H/2); rel = ~pull; tick(H/2); scl = 1'b0;
      tick(1); m_sda = 1'b1; tick(H-1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic a;
      logic st, rl;
      logic [7:0] d;
      int w0, s0;
      tick(5);
      rst_n = 1'b1;
      tick(5);
      chk("R1 reset pull", int'(pull), 0);
      chk("R1 reset strobes", int'(wr_stb | rd_req), 0);

      // R1: bytes clocked without a start condition are not acknowledged
      sbyte(8'hAA, a);
      chk("R1 no start no ack", int'(a), 0);

      // R3 R4 R5: write three bytes from 0x031E, wrapping inside the page
      s0 = stop_cnt; w0 = wr_cnt;
      bstart;
      sbyte(8'hAA, a); chk("R2 select ack", int'(a), 1);
      sbyte(8'hE3, a); chk("R3 high addr ack", int'(a), 1);
      sbyte(8'h1E, a); chk("R3 low addr ack", int'(a), 1);
      sbyte(8'h11, a); chk("R4 data ack", int'(a), 1);
      chk("R3 R4 first addr", int'(last_wa), 'h031E);
      chk("R4 first data", int'(last_wd), 'h11);
      sbyte(8'h22, a);
      chk("R5 second addr", int'(last_wa), 'h031F);
      sbyte(8'h33, a);
      chk("R5 page wrap addr", int'(last_wa), 'h0300);
      chk("R4 third data", int'(last_wd), 'h33);
      bstop;
      chk("R4 strobe count", wr_cnt - w0, 3);
      chk("R11 stop pulse", stop_cnt - s0, 1);

      // R10: current address read after the last write
      bstart;
      sbyte(8'hAB, a); chk("R10 read select ack", int'(a), 1);
      rbyte(1'b0, d, st, rl);
      chk("R10 current read data", int'(d), int'(pat(13'h0301)));
      chk("R8 stable in high", int'(st), 1);
      chk("R9 released on nack", int'(rl), 1);
      bstop;

      // R2: foreign straps and foreign type are ignored
      w0 = wr_cnt;
      bstart;
      sbyte(8'hA4, a); chk("R2 strap mismatch", int'(a), 0);
      sbyte(8'h00, a); chk("R2 ignored byte", int'(a), 0);
      bstop;
      bstart;
      sbyte(8'hBA, a); chk("R2 type mismatch", int'(a), 0);
      bstop;
      chk("R2 no write", wr_cnt - w0, 0);

      // R6: busy suppresses the select acknowledge
      busy = 1'b1;
      bstart; sbyte(8'hAA, a); bstop;
      chk("R6 busy no ack", int'(a), 0);
      busy = 1'b0;
      bstart; sbyte(8'hAA, a); bstop;
      chk("R6 poll ack", int'(a), 1);

      // R7: protection refuses data but not addresses
      wp = 1'b1; w0 = wr_cnt;
      bstart;
      sbyte(8'hAA, a);
      sbyte(8'h00, a); chk("R7 high addr ack", int'(a), 1);
      sbyte(8'h40, a); chk("R7 low addr ack", int'(a), 1);
      sbyte(8'h77, a); chk("R7 data nack", int'(a), 0);
      sbyte(8'h88, a); chk("R7 later nack", int'(a), 0);
      bstop;
      wp = 1'b0;
      chk("R7 no strobe", wr_cnt - w0, 0);
      bstart; sbyte(8'hAB, a); rbyte(1'b0, d, st, rl); bstop;
      chk("R7 pointer kept", int'(d), int'(pat(13'h0040)));

      // R9 R10: random read at 0x1FFE, sequential across the top
      bstart;
      sbyte(8'hAA, a); sbyte(8'h1F, a); sbyte(8'hFE, a);
      bstart;
      sbyte(8'hAB, a); chk("R10 repeated start ack", int'(a), 1);
      rbyte(1'b1, d, st, rl); chk("R10 random data", int'(d), int'(pat(13'h1FFE)));
      rbyte(1'b1, d, st, rl); chk("R9 next data", int'(d), int'(pat(13'h1FFF)));
      rbyte(1'b0, d, st, rl); chk("R9 wrap data", int'(d), int'(pat(13'h0000)));
      chk("R8 stable seq", int'(st), 1);
      chk("R9 release", int'(rl), 1);
      bstop;

      // R2: sweep every 7-bit select value
      for (int v = 0; v < 128; v++) begin
         bstart; sbyte({v[6:0], 1'b0}, a); bstop;
         chk($sformatf("R2 sweep %0h", v), int'(a), (v == 'h55) ? 1 : 0);
      end
      // R2: sweep every strap setting
      for (int s = 0; s < 8; s++) begin
         strap = s[2:0];
         bstart; sbyte(8'hAA, a); bstop;
         chk($sformatf("R2 strap %0d", s), int'(a), (s == 5) ? 1 : 0);
      end
      strap = 3'b101;

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule